// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides two 32-bit integers over many clock cycles. It covers the four division flavours a RISC-V integer core needs: signed and unsigned quotient, and signed and unsigned remainder. A caller pulses a start input with an opcode and two operands. The block converts the operands to magnitudes and then runs a restoring shift-subtract loop. Each step of the loop is steered by a one-hot quotient mask that walks from the top bit toward bit 0. After the loop, the block picks either the quotient or the remainder, passes that single value through one conditional negator, and registers it. A one-cycle done pulse marks the result as valid.

The finished condition does not test the whole mask for zero. It reads one fixed mask bit. A build-time switch selects an accelerated stepping mode for simulation. In that mode the mask jumps five positions per step, so a run ends after seven steps. The value that mode produces is not an arithmetic result. The mode only exercises the control path quickly.

Top module: `iter_divider`

## Requirements
- R1: With op_i = 2'b01 (bit 1 low selects the quotient, bit 0 high selects unsigned), result_o is the unsigned quotient floor(dividend/divisor) for a nonzero divisor.
- R2: With op_i = 2'b11 (remainder, unsigned), result_o is the unsigned remainder for a nonzero divisor.
- R3: With op_i = 2'b00 (quotient, signed), result_o is the two's-complement quotient truncated toward zero.
- R4: With op_i = 2'b10 (remainder, signed), result_o is the remainder of truncating division and carries the sign of the dividend.
- R5: When the divisor is zero, the quotient operations return 32'hFFFF_FFFF and the remainder operations return the dividend unchanged, for both signed and unsigned operations.
- R6: A signed division of 32'h8000_0000 by 32'hFFFF_FFFF returns 32'h8000_0000 as the quotient and 0 as the remainder.
- R7: In normal mode, done_o rises exactly 32 clock cycles after the edge that accepts start_i, and it stays high for exactly one cycle.
- R8: A start_i pulse that arrives while busy_o is high is ignored. The running division finishes with its own operands, and no second done_o follows from the ignored pulse.
- R9: While rst is high and on the cycle after it, busy_o and done_o are low. The first cycle after reset has result_o equal to zero.
- R10: With FAST_STEP = 1, the mask visits bits 31, 26, 21, 16, 11, 6 and 1, and done_o rises 7 cycles after the accepting edge.
- R11: busy_o is high from the cycle after the accepting edge until the cycle in which done_o is high. In that cycle it is low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a division; taken only while idle |
| op_i | input | 2 | Operation: bit 1 selects remainder, bit 0 selects unsigned |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | 32 | Registered result, held until the next completion |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a running division. The stimulus launches one division, waits a dozen cycles, and then pulses start with different operands and a different opcode. It checks that the result matches the first operands, that the latency is counted from the first start, and that done_o stays low for a long window afterwards. The accelerated mode runs in a second instance, where only its seven-step latency is checked. The sign corner cases use the most negative dividend against -1, zero divisors with both signs, and operands whose remainder is zero.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned OP_W = 2;

  typedef struct packed {
    logic want_rem;   // op bit 1
    logic is_uns;     // op bit 0
  } div_op_t;

  function automatic div_op_t decode_op(input logic [OP_W-1:0] op);
    div_op_t d;
    d.want_rem = op[1];
    d.is_uns   = op[0];
    return d;
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned XLEN = 32
) (
  input  div_pkg::div_op_t  op,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [XLEN-1:0]   a_mag_o,
  output logic [XLEN-1:0]   b_mag_o,
  output logic              neg_quo_o,
  output logic              neg_rem_o
);
  logic a_neg, b_neg, b_nz;

  always_comb begin
    a_neg     = !op.is_uns && a_i[XLEN-1];
    b_neg     = !op.is_uns && b_i[XLEN-1];
    b_nz      = |b_i;
    a_mag_o   = a_neg ? (~a_i + 1'b1) : a_i;
    b_mag_o   = b_neg ? (~b_i + 1'b1) : b_i;
    neg_quo_o = (a_neg ^ b_neg) && b_nz;
    neg_rem_o = a_neg;
  end
endmodule

// File: rtl/div_step_core.sv
module div_step_core #(
  parameter int unsigned XLEN      = 32,
  parameter bit          FAST_STEP = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [XLEN-1:0] a_mag_i,
  input  logic [XLEN-1:0] b_mag_i,
  output logic            run_o,
  output logic            last_o,
  output logic [XLEN-1:0] mask_o,
  output logic [XLEN-1:0] quo_nx_o,
  output logic [XLEN-1:0] rem_nx_o
);
  localparam int unsigned STEP    = FAST_STEP ? 5 : 1;
  localparam int unsigned DW      = 2*XLEN - 1;
  localparam int unsigned FIN_BIT = (XLEN-1) % STEP;

  logic [XLEN-1:0] rem_q, quo_q, mask_q;
  logic [DW-1:0]   div_q;
  logic            run_q;
  logic            take;

  always_comb begin
    take     = div_q <= {{(XLEN-1){1'b0}}, rem_q};
    rem_nx_o = take ? rem_q - div_q[XLEN-1:0] : rem_q;
    quo_nx_o = take ? (quo_q | mask_q) : quo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      mask_q <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      rem_q  <= a_mag_i;
      quo_q  <= '0;
      mask_q <= {1'b1, {(XLEN-1){1'b0}}};
      div_q  <= {b_mag_i, {(XLEN-1){1'b0}}};
      run_q  <= 1'b1;
    end else if (run_q) begin
      rem_q  <= rem_nx_o;
      quo_q  <= quo_nx_o;
      div_q  <= div_q >> 1;
      mask_q <= mask_q >> STEP;
      if (mask_q[FIN_BIT]) run_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign last_o = run_q && mask_q[FIN_BIT];
  assign mask_o = mask_q;
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int unsigned XLEN = 32
) (
  input  logic            pick_rem_i,
  input  logic            neg_quo_i,
  input  logic            neg_rem_i,
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] rem_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] chosen;
  logic            flip;

  always_comb begin
    chosen = pick_rem_i ? rem_i : quo_i;
    flip   = pick_rem_i ? neg_rem_i : neg_quo_i;
    res_o  = flip ? (~chosen + 1'b1) : chosen;
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int unsigned XLEN      = 32,
  parameter bit          FAST_STEP = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  import div_pkg::*;

  div_op_t         op_now;
  logic [XLEN-1:0] a_mag, b_mag, quo_nx, rem_nx, fixed, core_mask;
  logic            neg_quo, neg_rem, run, last, accept;
  logic            pick_rem_q, neg_quo_q, neg_rem_q, done_q;
  logic [XLEN-1:0] result_q;

  assign op_now = decode_op(op_i);
  assign accept = start_i && !run;

  div_operand_prep #(.XLEN(XLEN)) u_prep (
    .op(op_now), .a_i(dividend_i), .b_i(divisor_i),
    .a_mag_o(a_mag), .b_mag_o(b_mag),
    .neg_quo_o(neg_quo), .neg_rem_o(neg_rem)
  );

  div_step_core #(.XLEN(XLEN), .FAST_STEP(FAST_STEP)) u_core (
    .clk(clk), .rst(rst), .load_i(accept),
    .a_mag_i(a_mag), .b_mag_i(b_mag),
    .run_o(run), .last_o(last), .mask_o(core_mask),
    .quo_nx_o(quo_nx), .rem_nx_o(rem_nx)
  );

  div_sign_fix #(.XLEN(XLEN)) u_fix (
    .pick_rem_i(pick_rem_q), .neg_quo_i(neg_quo_q), .neg_rem_i(neg_rem_q),
    .quo_i(quo_nx), .rem_i(rem_nx), .res_o(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_rem_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      done_q     <= 1'b0;
      result_q   <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        pick_rem_q <= op_now.want_rem;
        neg_quo_q  <= neg_quo;
        neg_rem_q  <= neg_rem;
      end
      if (last) result_q <= fixed;
    end
  end

  assign busy_o   = run;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int unsigned XLEN      = 32,
  parameter bit          FAST_STEP = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] mask
);
  localparam int unsigned STEP    = FAST_STEP ? 5 : 1;
  localparam int unsigned ITERS   = (XLEN-1)/STEP + 1;
  localparam int unsigned FIN_BIT = (XLEN-1) % STEP;

  logic [7:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !busy) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_q == 8'(ITERS)));

  assert_mask_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(mask) == 1));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !mask[FIN_BIT]) |=> busy);

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done));
endmodule

bind iter_divider div_checker #(.XLEN(XLEN), .FAST_STEP(FAST_STEP)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_o), .done(done_o), .mask(core_mask)
);

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, start_f = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, busy_f, done_f;
  logic [31:0] res, res_f;
  int          checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_divider #(.XLEN(32), .FAST_STEP(1'b0)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  iter_divider #(.XLEN(32), .FAST_STEP(1'b1)) u_fast (
    .clk(clk), .rst(rst), .start_i(start_f), .op_i(op),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy_f), .done_o(done_f), .result_o(res_f)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    logic signed [31:0] sx, sy;
    sx = x; sy = y;
    if (y == 0) return o[1] ? x : 32'hFFFF_FFFF;
    if (o[0]) return o[1] ? x % y : x / y;
    if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return o[1] ? 32'h0 : x;
    return o[1] ? 32'(sx % sy) : 32'(sx / sy);
  endfunction

  // launches one division and waits for done; returns latency in cycles
  task automatic launch(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y,
                        output int lat);
    @(negedge clk);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    int lat;
    launch(o, x, y, lat);
    check(req, res, model(o, x, y));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 busy", {31'b0, busy}, 32'h0);
    check("R9 done", {31'b0, done}, 32'h0);
    check("R9 result", res, 32'h0);
  endtask

  task automatic t_unsigned;
    run_op("R1", 2'b01, 32'd100, 32'd7);
    run_op("R1", 2'b01, 32'hFFFF_FFFF, 32'd3);
    run_op("R1", 2'b01, 32'd5, 32'hF000_0000);
    run_op("R2", 2'b11, 32'd100, 32'd7);
    run_op("R2", 2'b11, 32'hDEAD_BEEF, 32'h0001_2345);
    run_op("R2", 2'b11, 32'd48, 32'd8);
  endtask

  task automatic t_signed;
    run_op("R3", 2'b00, -32'sd100, 32'd7);
    run_op("R3", 2'b00, 32'd100, -32'sd7);
    run_op("R3", 2'b00, -32'sd100, -32'sd7);
    run_op("R3", 2'b00, 32'h8000_0000, 32'd2);
    run_op("R4", 2'b10, -32'sd100, 32'd7);
    run_op("R4", 2'b10, 32'd100, -32'sd7);
    run_op("R4", 2'b10, -32'sd100, -32'sd7);
    run_op("R4", 2'b10, -32'sd48, 32'd8);
  endtask

  task automatic t_zero_div;
    run_op("R5 signed quo", 2'b00, -32'sd9, 32'd0);
    run_op("R5 unsigned quo", 2'b01, 32'd9, 32'd0);
    run_op("R5 signed rem", 2'b10, -32'sd9, 32'd0);
    run_op("R5 unsigned rem", 2'b11, 32'h8765_4321, 32'd0);
  endtask

  task automatic t_overflow;
    run_op("R6 quo", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R6 quo value", res, 32'h8000_0000);
    run_op("R6 rem", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R6 rem value", res, 32'h0);
  endtask

  task automatic t_timing;
    int lat;
    launch(2'b01, 32'd1000, 32'd10, lat);
    check("R7 latency", 32'(lat), 32'd32);
    check("R11 busy low at done", {31'b0, busy}, 32'h0);
    @(negedge clk);
    check("R7 pulse width", {31'b0, done}, 32'h0);
    @(negedge clk);
    op = 2'b01; a = 32'd50; b = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after accept", {31'b0, busy}, 32'h1);
    while (!done) @(negedge clk);
  endtask

  task automatic t_ignore;
    int lat;
    bit seen;
    @(negedge clk);
    op = 2'b01; a = 32'd999; b = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (11) begin @(negedge clk); lat++; end
    op = 2'b11; a = 32'd12345; b = 32'd77; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R8 latency from first start", 32'(lat), 32'd32);
    check("R8 result of first operands", res, 32'd111);
    seen = 1'b0;
    repeat (40) begin @(negedge clk); if (done || busy) seen = 1'b1; end
    check("R8 no second completion", {31'b0, seen}, 32'h0);
  endtask

  task automatic t_fast;
    int lat;
    @(negedge clk);
    op = 2'b01; a = 32'd77; b = 32'd3; start_f = 1'b1;
    @(negedge clk);
    start_f = 1'b0;
    lat = 0;
    while (!done_f && lat < 100) begin @(negedge clk); lat++; end
    check("R10 fast latency", 32'(lat), 32'd7);
    @(negedge clk);
    check("R10 fast pulse", {31'b0, done_f}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unsigned();
    t_signed();
    t_zero_div();
    t_overflow();
    t_timing();
    t_ignore();
    t_fast();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule